// File: doc/BRIEF.md
# Pipelined Tree Arbiter for Multi-Chip Distance Search

Several identical search chips run a distance search in lock-step. In each distance period, every chip whose array holds words at the current distance raises an activation request. This block gathers those requests through a binary tree of registered decision nodes and returns a one-hot grant to the winning chip. When several chips are active at once, the chip with the lowest index wins. It also returns a completion flag that tells every chip that some chip answered in that period.

Each chip carries one identical decision node. The node works out its level in the tree from the lowest set bit of its chip ID input. The tree is pipelined, so by the time a decision comes back down, a node's own view of its two children is several cycles old. Each node therefore keeps that view in a short shift buffer. The buffer tap is chosen by the node's level, and the buffer is sized for the largest supported chip count. A new request set may enter on every clock, and its answer leaves a fixed number of cycles later.

Top module: `ppd_arbiter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `grant_o` is all zeros and `done_o` is low.
- R2: When more than one bit of a request set is high, the grant goes only to the lowest-indexed active chip. Bit i of `grant_o` refers to the same chip as bit i of `act_req`.
- R3: `grant_o` never has more than one bit set.
- R4: `done_o` for a request set is high exactly when at least one bit of that set was high.
- R5: The grant and completion for the request set sampled at clock edge t appear on the outputs after edge t + 2·log2(NUM_CHIPS) − 1. The latency is the same whichever chip wins, and a new set is accepted on every edge.
- R6: A request set with no active bit gives an all-zero grant and a low `done_o`. This holds even when it directly follows or precedes busy sets, so no earlier decision leaks into it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| act_req | input | NUM_CHIPS | Activation request, one bit per chip, sampled every cycle |
| grant_o | output | NUM_CHIPS | Registered one-hot grant, bit i for chip i |
| done_o | output | 1 | Registered completion: some chip was active in that set |

## Verification
The 8-chip build is swept with all 256 request sets back to back. Every winner position is tried under every combination of higher-indexed competitors, so a wrong priority order or a wrong tap in any node's buffer shows up as a wrong winner. Walking-one sets isolate the latency of each leaf path, since each has only one possible winner. Walking-zero sets always make chip 0 or chip 1 the winner while the rest stay busy. A pseudo-random stream mixed with all-zero sets shows whether decisions from adjacent cycles leak into each other through the pipeline.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  typedef struct packed {
    logic lo;
    logic hi;
  } act_pair_t;

  // Position of the lowest set bit; 0 when the value is zero.
  function automatic int lsb_pos(input logic [31:0] v);
    int p;
    p = 0;
    for (int b = 31; b >= 0; b--) begin
      if (v[b]) p = b;
    end
    return p;
  endfunction

endpackage

// File: rtl/ppd_ret_delay.sv
module ppd_ret_delay
  import ppd_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int TAPW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TAPW-1:0] tap,
  input  act_pair_t       live,
  output act_pair_t       held
);

  act_pair_t stage_q [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < DEPTH; j++) stage_q[j] <= '0;
    end else begin
      stage_q[0] <= live;
      for (int j = 1; j < DEPTH; j++) stage_q[j] <= stage_q[j-1];
    end
  end

  // tap = 0 bypasses every stage; tap = n takes the value from n cycles ago
  always_comb begin
    held = live;
    for (int j = 0; j < DEPTH; j++) begin
      if (tap == TAPW'(j + 1)) held = stage_q[j];
    end
  end

endmodule

// File: rtl/ppd_prio_cell.sv
module ppd_prio_cell
  import ppd_pkg::*;
(
  input  act_pair_t pair,
  input  logic      grant_in,
  output logic      lo_grant,
  output logic      hi_grant
);

  always_comb begin
    lo_grant = grant_in & pair.lo;
    hi_grant = grant_in & ~pair.lo & pair.hi;
  end

endmodule

// File: rtl/ppd_node.sv
module ppd_node
  import ppd_pkg::*;
#(
  parameter int TREE_LVLS = 3,
  parameter int MAX_LVLS  = 4,
  parameter int IDW       = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [IDW-1:0] chip_id,
  input  logic           lo_act,
  input  logic           hi_act,
  input  logic           grant_in,
  output logic           up_act,
  output logic           lo_grant,
  output logic           hi_grant
);

  localparam int BUF_DEPTH = (2 * MAX_LVLS - 2 > 0) ? 2 * MAX_LVLS - 2 : 1;
  localparam int TAPW      = $clog2(BUF_DEPTH + 1);

  int            lvl;
  logic [TAPW-1:0] tap;
  act_pair_t     live_pair;
  act_pair_t     held_pair;
  logic          lo_g_c;
  logic          hi_g_c;

  // Chip-ID decode: level = lowest set bit; return delay shrinks by two per level
  always_comb begin
    lvl = lsb_pos(32'(chip_id));
    if (lvl >= TREE_LVLS - 1) tap = '0;
    else                      tap = TAPW'(2 * (TREE_LVLS - 1 - lvl));
    live_pair.lo = lo_act;
    live_pair.hi = hi_act;
  end

  ppd_ret_delay #(.DEPTH(BUF_DEPTH), .TAPW(TAPW)) u_delay (
    .clk  (clk),
    .rst  (rst),
    .tap  (tap),
    .live (live_pair),
    .held (held_pair)
  );

  ppd_prio_cell u_cell (
    .pair     (held_pair),
    .grant_in (grant_in),
    .lo_grant (lo_g_c),
    .hi_grant (hi_g_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      up_act   <= 1'b0;
      lo_grant <= 1'b0;
      hi_grant <= 1'b0;
    end else begin
      up_act   <= lo_act | hi_act;
      lo_grant <= lo_g_c;
      hi_grant <= hi_g_c;
    end
  end

endmodule

// File: rtl/ppd_arbiter.sv
module ppd_arbiter
  import ppd_pkg::*;
#(
  parameter int NUM_CHIPS = 8,
  parameter int MAX_CHIPS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_CHIPS-1:0] act_req,
  output logic [NUM_CHIPS-1:0] grant_o,
  output logic                 done_o
);

  localparam int LVLS     = $clog2(NUM_CHIPS);
  localparam int MAX_LVLS = $clog2(MAX_CHIPS);
  localparam int IDW      = (LVLS > 0) ? LVLS : 1;
  localparam int ROOT     = NUM_CHIPS / 2;

  logic up_c [1:NUM_CHIPS-1];
  logic gl_c [1:NUM_CHIPS-1];
  logic gr_c [1:NUM_CHIPS-1];
  logic [NUM_CHIPS-1:0] leaf_g;
  logic [LVLS-1:0]      done_sh;

  for (genvar i = 1; i < NUM_CHIPS; i++) begin : g_node
    localparam int K = lsb_pos(i);
    logic lo_a;
    logic hi_a;
    logic g_in;

    if (K == 0) begin : g_leafpair
      assign lo_a = act_req[i-1];
      assign hi_a = act_req[i];
    end else begin : g_inner
      assign lo_a = up_c[i - (1 << (K - 1))];
      assign hi_a = up_c[i + (1 << (K - 1))];
    end

    if (K == LVLS - 1) begin : g_root
      assign g_in = 1'b1;
    end else begin : g_child
      localparam int P = (i & ~(1 << K)) | (1 << (K + 1));
      if (((i >> (K + 1)) & 1) == 0) begin : g_left
        assign g_in = gl_c[P];
      end else begin : g_right
        assign g_in = gr_c[P];
      end
    end

    ppd_node #(.TREE_LVLS(LVLS), .MAX_LVLS(MAX_LVLS), .IDW(IDW)) u_node (
      .clk      (clk),
      .rst      (rst),
      .chip_id  (IDW'(i)),
      .lo_act   (lo_a),
      .hi_act   (hi_a),
      .grant_in (g_in),
      .up_act   (up_c[i]),
      .lo_grant (gl_c[i]),
      .hi_grant (gr_c[i])
    );
  end

  for (genvar j = 0; j < NUM_CHIPS; j++) begin : g_leaf
    if (j % 2 == 1) begin : g_odd
      assign leaf_g[j] = gr_c[j];
    end else begin : g_even
      assign leaf_g[j] = gl_c[j+1];
    end
  end

  // Completion leaves the root and rides the return path down to every chip
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o <= '0;
      done_sh <= '0;
    end else begin
      grant_o    <= leaf_g;
      done_sh[0] <= up_c[ROOT];
      for (int j = 1; j < LVLS; j++) done_sh[j] <= done_sh[j-1];
    end
  end

  assign done_o = done_sh[LVLS-1];

endmodule

// File: rtl/ppd_arbiter_chk.sv
module ppd_arbiter_chk #(
  parameter int NUM_CHIPS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_CHIPS-1:0] act_req,
  input logic [NUM_CHIPS-1:0] grant_o,
  input logic                 done_o
);

  localparam int LAT = 2 * $clog2(NUM_CHIPS);

  logic [NUM_CHIPS-1:0] req_sh [LAT];
  logic [NUM_CHIPS-1:0] oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < LAT; j++) req_sh[j] <= '0;
    end else begin
      req_sh[0] <= act_req;
      for (int j = 1; j < LAT; j++) req_sh[j] <= req_sh[j-1];
    end
  end

  assign oldest = req_sh[LAT-1];

  a_r1_clear_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (grant_o == '0 && !done_o));

  a_r2_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    grant_o == (oldest & (~oldest + NUM_CHIPS'(1))));

  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  a_r4_done_tracks_grant: assert property (@(posedge clk) disable iff (rst)
    done_o == (grant_o != '0));

  a_r5_fixed_latency: assert property (@(posedge clk) disable iff (rst)
    done_o == (oldest != '0));

  a_r6_idle_no_grant: assert property (@(posedge clk) disable iff (rst)
    (oldest == '0) |-> (grant_o == '0 && !done_o));

endmodule

bind ppd_arbiter ppd_arbiter_chk #(.NUM_CHIPS(NUM_CHIPS)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .act_req (act_req),
  .grant_o (grant_o),
  .done_o  (done_o)
);

// File: tb/ppd_arbiter_tb_top.sv
module ppd_arbiter_tb_top;

  localparam int N   = 8;
  localparam int LAT = 6;
  localparam int NV  = 480;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] act_req = '0;
  logic [N-1:0] grant_o;
  logic         done_o;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] hist [NV];

  ppd_arbiter #(.NUM_CHIPS(N), .MAX_CHIPS(16)) dut_i (
    .clk     (clk),
    .rst     (rst),
    .act_req (act_req),
    .grant_o (grant_o),
    .done_o  (done_o)
  );

  always #5 clk = ~clk;

  task automatic check_val(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    // Exhaustive sweep, walking one, walking zero, then random mixed with idle sets
    for (int k = 0; k < NV; k++) begin
      if (k < 256) hist[k] = N'(k);
      else if (k < 264) hist[k] = N'(1) << (k - 256);
      else if (k < 272) hist[k] = ~(N'(1) << (k - 264));
      else begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        hist[k] = (k % 5 == 0) ? '0 : lfsr[N-1:0];
      end
    end

    repeat (3) @(negedge clk);
    // R1: outputs clear while in reset
    check_val("R1", int'(grant_o), 0);
    check_val("R1", int'(done_o), 0);
    rst = 1'b0;

    for (int k = 0; k < NV + LAT + 2; k++) begin
      @(negedge clk);
      if (k < LAT) begin
        // R1: only reset-cleared pipeline contents can reach the outputs yet
        check_val("R1", int'(grant_o), 0);
        check_val("R1", int'(done_o), 0);
      end else if (k - LAT < NV) begin
        logic [N-1:0] v;
        logic [N-1:0] exp_g;
        v = hist[k - LAT];
        exp_g = v & (~v + N'(1));
        if ($countones(v) > 1)       check_val("R2", int'(grant_o), int'(exp_g));
        else if ($countones(v) == 1) check_val("R5", int'(grant_o), int'(exp_g));
        else                         check_val("R6", int'(grant_o), 0);
        check_val("R3", int'($onehot0(grant_o)), 1);
        check_val("R4", int'(done_o), int'(v != '0));
      end else begin
        check_val("R6", int'(grant_o), 0);
        check_val("R6", int'(done_o), 0);
      end
      act_req = (k < NV) ? hist[k] : '0;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule